// File: doc/BRIEF.md
# Optimal Adder Increment Search

This block chooses the increment for an accumulator-style pattern generator. The generator starts from a seed and adds a fixed increment on each clock. The block finds the increment that reaches every pattern in a given set within the fewest additions. Software or a controller writes M words of W bits into a small register array. Slot 0 holds the seed, and the other slots hold the patterns that must show up in the generated stream. A start strobe then runs the search.

The search works on the multiplicative inverse Y of the increment. For a candidate Y, the number of additions needed to reach pattern i is Y·(Vi − V0) mod 2^W. The sequence length is the largest of these values. The block builds a threshold one bit at a time, starting at the most significant bit. For each bit it tries the threshold with that bit cleared, and it keeps the bit cleared only if some odd Y meets the threshold. Candidate Ys are scanned in ascending order, one per cycle, and all vector lengths are evaluated in parallel. When the threshold is settled, a short Newton iteration turns the winning Y into the increment. The block then pulses done.

Top module: `incr_search`

## Requirements
- R1: While the block is idle, a write with wr_en high stores wr_val into slot wr_idx. Slot 0 is the seed. A write with wr_idx ≥ M is ignored, and so is any write made while a search runs.
- R2: A start pulse while idle begins a search. A start pulse during a search is ignored, so the search neither restarts nor lengthens.
- R3: When done is high, min_len equals the smallest value, over all odd Y, of the maximum over i ≥ 1 of Y·(Vi − V0) mod 2^W, with the difference also taken mod 2^W.
- R4: When done is high, best_y is the smallest odd Y whose maximum length equals min_len.
- R5: When done is high, incr·best_y ≡ 1 (mod 2^W).
- R6: Reset gives min_len = 0, best_y = 1, incr = 1 and done low. Done is high for exactly one cycle per search. While idle with no start, all three results hold their values.
- R7: Done rises no more than W·2^(W−1) + clog2(W) + 3 cycles after the start pulse.
- R8: With M = 1, a start gives min_len = 0, best_y = 1 and incr = 1, with done one cycle later.
- R9: With W = 6 and vectors {0, 59, 60, 61, 62}, the result is min_len = 5, best_y = 63, incr = 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Vector write enable |
| wr_idx | input | IW | Slot to write (0 = seed) |
| wr_val | input | W | Vector value |
| start | input | 1 | Begin the search |
| min_len | output | W | Minimal longest sequence length |
| best_y | output | W | Winning multiplier Y |
| incr | output | W | Adder increment, inverse of best_y |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that start is a single-cycle strobe applied only after reset is released. They also assume that the results are read only in the cycle of done or while the block is idle, because incr changes during the inverse iteration. The bench raises start for exactly one cycle per run and reads the results at done. Its deliberate stray start and mid-search write are both issued while the block is busy, where the requirements say they are ignored.

// File: rtl/incr_search.sv
module incr_search #(
  parameter int W = 6,
  parameter int M = 5,
  localparam int IW = (M > 1) ? $clog2(M) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_val,
  input  logic          start,
  output logic [W-1:0]  min_len,
  output logic [W-1:0]  best_y,
  output logic [W-1:0]  incr,
  output logic          done
);
  localparam int BW = (W > 1) ? $clog2(W) : 1;
  localparam int NITER = $clog2(W) + 1;
  localparam int CW = $clog2(NITER + 1);

  typedef enum logic [1:0] {IDLE, SCAN, INV} st_t;

  st_t st;
  logic [W-1:0] vec [M];
  logic [W-1:0] thr, y, best, x, maxlen, prod, tent, nb;
  logic [BW-1:0] bitpos;
  logic [CW-1:0] it;
  logic hit, last_y, busy;

  assign busy = st != IDLE;

  always_comb begin
    maxlen = '0;
    prod = '0;
    for (int i = 1; i < M; i++) begin
      prod = y * (vec[i] - vec[0]);
      if (prod > maxlen) maxlen = prod;
    end
  end

  assign tent = thr & ~(W'(1) << bitpos);
  assign hit = maxlen <= tent;
  assign last_y = &y;
  assign nb = hit ? y : best;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < M; i++) vec[i] <= '0;
    end else if (wr_en && !busy && 32'(wr_idx) < M) begin
      vec[wr_idx] <= wr_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE;
      thr <= '0;
      best <= W'(1);
      x <= W'(1);
      y <= W'(1);
      bitpos <= '0;
      it <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (start) begin
          if (M == 1) begin
            thr <= '0;
            best <= W'(1);
            x <= W'(1);
            done <= 1'b1;
          end else begin
            st <= SCAN;
            thr <= '1;
            best <= W'(1);
            y <= W'(1);
            bitpos <= BW'(W - 1);
          end
        end
        SCAN: begin
          if (hit) begin
            thr <= tent;
            best <= y;
          end
          if (hit || last_y) begin
            y <= W'(1);
            if (bitpos == '0) begin
              st <= INV;
              x <= nb;
              it <= '0;
            end else begin
              bitpos <= bitpos - 1'b1;
            end
          end else begin
            y <= y + W'(2);
          end
        end
        INV: begin
          x <= x * (W'(2) - best * x);
          it <= it + 1'b1;
          if (it == CW'(NITER - 1)) begin
            st <= IDLE;
            done <= 1'b1;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  assign min_len = thr;
  assign best_y = best;
  assign incr = x;
endmodule

// File: rtl/incr_search_chk.sv
module incr_search_chk #(
  parameter int W = 6
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] min_len,
  input logic [W-1:0] best_y,
  input logic [W-1:0] incr
);
  logic [W-1:0] inv_chk;
  assign inv_chk = incr * best_y;

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(min_len) && $stable(best_y) && $stable(incr)));

  p_inverse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> inv_chk == W'(1));

  p_odd_y_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> best_y[0]);

  p_start_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy || done));

  p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind incr_search incr_search_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .min_len(min_len), .best_y(best_y), .incr(incr)
);

// File: tb/incr_search_test.sv
`timescale 1ns/1ps
module incr_search_test;
  localparam int W = 6;
  localparam int M = 5;
  localparam int MASK = (1 << W) - 1;
  localparam int BOUND = W * (1 << (W - 1)) + $clog2(W) + 3;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, start = 0;
  logic [2:0] wr_idx = '0;
  logic [W-1:0] wr_val = '0;
  logic [W-1:0] min_len, best_y, incr;
  logic done;
  logic start1 = 0;
  logic [W-1:0] min_len1, best_y1, incr1;
  logic done1;

  int nchk = 0, nfail = 0, cycles = 0;
  int tv[M];
  int lcg = 12345;

  always #2 clk = ~clk;

  incr_search #(.W(W), .M(M)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val),
    .start(start), .min_len(min_len), .best_y(best_y), .incr(incr), .done(done));

  incr_search #(.W(W), .M(1)) uut_single (
    .clk(clk), .rst_n(rst_n), .wr_en(1'b0), .wr_idx(1'b0), .wr_val('0),
    .start(start1), .min_len(min_len1), .best_y(best_y1), .incr(incr1), .done(done1));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nfail++;
      $display("FAIL watchdog actual %0d expected %0d", cycles, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  task automatic wr(input int idx, input int val);
    @(negedge clk);
    wr_en = 1; wr_idx = 3'(idx); wr_val = W'(val);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic load();
    for (int i = 0; i < M; i++) wr(i, tv[i]);
  endtask

  function automatic void ref_search(output int rl, output int ry);
    rl = MASK + 1; ry = 1;
    for (int yy = 1; yy <= MASK; yy += 2) begin
      int mx = 0;
      for (int i = 1; i < M; i++) begin
        int p = (yy * ((tv[i] - tv[0]) & MASK)) & MASK;
        if (p > mx) mx = p;
      end
      if (mx < rl) begin rl = mx; ry = yy; end
    end
  endfunction

  function automatic int ref_inv(input int yy);
    for (int xx = 1; xx <= MASK; xx += 2)
      if (((xx * yy) & MASK) == 1) return xx;
    return 0;
  endfunction

  task automatic run(input int poke_at, input bit poke_start, input bit poke_wr, output int cyc);
    @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    cyc = 1;
    while (!done && cyc < 1000) begin
      if (cyc == poke_at) begin
        start = poke_start;
        if (poke_wr) begin wr_en = 1; wr_idx = 3'd1; wr_val = W'(tv[1] ^ 21); end
      end else begin
        start = 0; wr_en = 0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 0; wr_en = 0;
  endtask

  task automatic run_check(input int poke_at, input bit poke_start, input bit poke_wr, output int cyc);
    int rl, ry;
    ref_search(rl, ry);
    run(poke_at, poke_start, poke_wr, cyc);
    chk(done === 1'b1, "R7 done seen", int'(done), 1);
    chk(cyc <= BOUND, "R7 latency", cyc, BOUND);
    chk(int'(min_len) == rl, "R3 min_len", int'(min_len), rl);
    chk(int'(best_y) == ry, "R4 best_y", int'(best_y), ry);
    chk(int'(incr) == ref_inv(ry), "R5 incr", int'(incr), ref_inv(ry));
    @(negedge clk);
    chk(done === 1'b0, "R6 done pulse", int'(done), 0);
    @(negedge clk);
    chk(int'(min_len) == rl && int'(best_y) == ry, "R6 hold", int'(min_len), rl);
  endtask

  initial begin
    int cyc, cyc0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(min_len == 0, "R6 reset min_len", int'(min_len), 0);
    chk(best_y == 1, "R6 reset best_y", int'(best_y), 1);
    chk(incr == 1, "R6 reset incr", int'(incr), 1);
    chk(done == 0, "R6 reset done", int'(done), 0);

    tv = '{0, 59, 60, 61, 62};
    load();
    run_check(0, 0, 0, cyc);
    chk(min_len == 5 && best_y == 63 && incr == 63, "R9 example", int'(best_y), 63);

    tv = '{17, 17, 17, 17, 17};
    load();
    run_check(0, 0, 0, cyc);
    chk(min_len == 0 && best_y == 1 && incr == 1, "R3 equal set", int'(min_len), 0);

    tv = '{5, 37, 5, 37, 5};
    load();
    run_check(0, 0, 0, cyc);
    chk(min_len == 32, "R3 half-range diff", int'(min_len), 32);

    for (int s = 0; s < 40; s++) begin
      for (int i = 0; i < M; i++) begin
        lcg = lcg * 1103515245 + 12345;
        tv[i] = (lcg >>> 16) & MASK;
      end
      load();
      run_check(0, 0, 0, cyc);
    end

    tv = '{9, 1, 44, 23, 60};
    load();
    run_check(0, 0, 0, cyc0);
    run_check(10, 1, 0, cyc);
    chk(cyc == cyc0, "R2 stray start ignored", cyc, cyc0);

    run_check(7, 0, 1, cyc);
    run_check(0, 0, 0, cyc);
    for (int k = M; k < 8; k++) wr(k, 63);
    run_check(0, 0, 0, cyc);
    chk(cyc == cyc0, "R1 out-of-range write ignored", cyc, cyc0);

    @(negedge clk);
    start1 = 1;
    @(negedge clk);
    start1 = 0;
    chk(done1 === 1'b1, "R8 single done", int'(done1), 1);
    chk(min_len1 == 0 && best_y1 == 1, "R8 single len", int'(min_len1), 0);
    chk(incr1 == 1, "R8 single incr", int'(incr1), 1);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule